// File: doc/BRIEF.md
# Next-Interrupt Service CSR Logic

This block handles the read-modify-write of the next-interrupt CSR in a core whose local interrupt controller arbitrates by level. There is one such CSR for machine mode and one for supervisor mode. A running handler reads this CSR to learn whether another pending interrupt can be taken at once, without returning and trapping again. If it can, the read returns the address of that interrupt's vector table entry. The same access records the new interrupt as the one in service. It copies the interrupt's level into the current-level field of the active mode and its exception code into the cause code field of that mode.

The interrupt may be taken only if all of these hold:
- a nonzero code is pending;
- the controller runs in its level-based mode;
- the interrupt targets the privilege that is executing now;
- it is not set up for hardware vectoring;
- its level is strictly above the larger of two values: the saved previous level from the active cause register and the active mode's threshold.

Any write that comes with the access sets low status bits. A user-mode access is flagged as illegal. The arbitration tree and the vector table memory are outside this block.

Top module: `nxti_csr`

## Requirements
- R1: A legal access to a serviceable interrupt returns `vec_base + pend_id * (XLEN/8)` and loads `pend_lvl` and `pend_code` into the current-level and cause-code outputs of the executing mode.
- R2: The effective level is the maximum of the active mode's saved previous level and its threshold. An interrupt whose level equals that maximum is not serviced. An interrupt one level above it is serviced.
- R3: A pending interrupt whose privilege (U=0, S=1, M=3) differs from `cur_priv` is not serviced.
- R4: A pending exception code of zero is never serviced.
- R5: When `lvl_mode` is 0, no interrupt is serviced.
- R6: A pending interrupt with `pend_hwvec`=1 is not serviced.
- R7: When no interrupt is serviced, the response data is zero and the level and code outputs of both modes keep their values.
- R8: A legal access with a nonzero write mask ORs `wdata & wmask` into `stat_lo[4:0]`. Write-data bits above bit 4 are ignored. A zero mask changes nothing, and no status bit is ever cleared.
- R9: An access at user privilege (`cur_priv`=0) raises `rsp_err`, returns zero and changes no state.
- R10: An access to the machine address 0x345 at supervisor privilege raises `rsp_err` and changes no state.
- R11: At supervisor privilege, an access to 0x145 compares against the supervisor previous level and threshold. It updates only the supervisor level and code outputs.
- R12: Every access to 0x345 or 0x145 gives exactly one `rsp_valid` pulse, one cycle later. Other addresses give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_valid | input | 1 | CSR access strobe |
| csr_addr | input | 12 | CSR address |
| wdata | input | XLEN | Write data |
| wmask | input | XLEN | Write mask |
| cur_priv | input | 2 | Executing privilege |
| lvl_mode | input | 1 | Controller is in level-based mode |
| pend_code | input | CODE_W | Pending exception code, 0 = none |
| pend_priv | input | 2 | Privilege of pending interrupt |
| pend_lvl | input | LVL_W | Level of pending interrupt |
| pend_id | input | ID_W | Interrupt identifier |
| pend_hwvec | input | 1 | Pending interrupt is hardware vectored |
| m_prev_lvl | input | LVL_W | Machine cause previous-level field |
| s_prev_lvl | input | LVL_W | Supervisor cause previous-level field |
| m_thresh | input | LVL_W | Machine threshold |
| s_thresh | input | LVL_W | Supervisor threshold |
| vec_base | input | XLEN | Vector table base |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | XLEN | Read data |
| rsp_err | output | 1 | Illegal access |
| stat_lo | output | 5 | Status bits 4:0 |
| m_cur_lvl | output | LVL_W | Machine current level |
| s_cur_lvl | output | LVL_W | Supervisor current level |
| m_code | output | CODE_W | Machine cause code field |
| s_code | output | CODE_W | Supervisor cause code field |

## Verification
The bench keeps the default parameters: XLEN=32, LVL_W=8, ID_W=12 and CODE_W=12. With these values the table stride is four bytes, and a largest identifier of 4095 tests that the shifted index is added to the base without being truncated. The 8-bit level lets the bench use level 255, which is the top of the comparison range. It also exercises the equal-to-maximum boundary with each of the two operands being the larger one.

// File: rtl/nxti_pkg.sv
// Shared encodings for the next-interrupt CSR logic.
// Assumes the standard two-bit privilege encoding.
package nxti_pkg;
    typedef enum logic [1:0] {
        PRV_U   = 2'd0,
        PRV_S   = 2'd1,
        PRV_RSV = 2'd2,
        PRV_M   = 2'd3
    } priv_e;

    localparam logic [11:0] ADDR_M_NXTI = 12'h345;
    localparam logic [11:0] ADDR_S_NXTI = 12'h145;
    localparam int unsigned STAT_W      = 5;
endpackage

// File: rtl/nxti_eval.sv
// Decides, combinationally, whether the pending interrupt may be serviced
// from within the running handler. Assumes the caller only consults the
// result for a legal M or S access.
module nxti_eval
    import nxti_pkg::*;
#(
    parameter int unsigned LVL_W  = 8,
    parameter int unsigned CODE_W = 12
) (
    input  logic [1:0]        cur_priv,
    input  logic              lvl_mode,
    input  logic [CODE_W-1:0] pend_code,
    input  logic [1:0]        pend_priv,
    input  logic [LVL_W-1:0]  pend_lvl,
    input  logic              pend_hwvec,
    input  logic [LVL_W-1:0]  m_prev_lvl,
    input  logic [LVL_W-1:0]  s_prev_lvl,
    input  logic [LVL_W-1:0]  m_thresh,
    input  logic [LVL_W-1:0]  s_thresh,
    output logic              svc
);
    logic [LVL_W-1:0] prev_sel;
    logic [LVL_W-1:0] thr_sel;
    logic [LVL_W-1:0] eff_lvl;

    // Pick the active mode's saved level and threshold.
    always_comb begin
        if (cur_priv == PRV_M) begin
            prev_sel = m_prev_lvl;
            thr_sel  = m_thresh;
        end else begin
            prev_sel = s_prev_lvl;
            thr_sel  = s_thresh;
        end
    end

    // Effective comparison level is the larger of the two.
    always_comb eff_lvl = (prev_sel > thr_sel) ? prev_sel : thr_sel;

    // All gating conditions for servicing a horizontal interrupt.
    always_comb begin
        svc = (pend_code != '0)
            && lvl_mode
            && (pend_priv == cur_priv)
            && !pend_hwvec
            && (pend_lvl > eff_lvl);
    end
endmodule

// File: rtl/nxti_addr.sv
// Forms the vector table entry address: base plus identifier times the
// register byte width. Assumes XLEN is a power of two of at least 8.
module nxti_addr #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned ID_W = 12
) (
    input  logic [XLEN-1:0] vec_base,
    input  logic [ID_W-1:0] pend_id,
    output logic [XLEN-1:0] vec_addr
);
    localparam int unsigned SHIFT = $clog2(XLEN / 8);

    logic [XLEN-1:0] id_ext;

    // Zero-extend the identifier to the address width.
    always_comb id_ext = XLEN'(pend_id);

    // Scale the identifier by the entry size and add it to the base.
    always_comb vec_addr = vec_base + (id_ext << SHIFT);
endmodule

// File: rtl/nxti_state.sv
// Holds the registered response and the interrupt state that the CSR
// access updates. Assumes err is only meaningful when acc is high.
module nxti_state
    import nxti_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned LVL_W  = 8,
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              err,
    input  logic              svc,
    input  logic              mode_m,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_bits,
    input  logic [XLEN-1:0]   vec_addr,
    input  logic [CODE_W-1:0] pend_code,
    input  logic [LVL_W-1:0]  pend_lvl,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_data,
    output logic              rsp_err,
    output logic [STAT_W-1:0] stat_lo,
    output logic [LVL_W-1:0]  m_cur_lvl,
    output logic [LVL_W-1:0]  s_cur_lvl,
    output logic [CODE_W-1:0] m_code,
    output logic [CODE_W-1:0] s_code
);
    logic ok;
    logic take;

    always_comb ok   = acc && !err;
    always_comb take = ok && svc;

    // Register the response of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= acc;
            rsp_err   <= acc && err;
            rsp_data  <= take ? vec_addr : '0;
        end
    end

    // Set status bits selected by a masked write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_lo <= '0;
        end else if (ok && wr_en) begin
            stat_lo <= stat_lo | wr_bits;
        end
    end

    // Record the serviced interrupt for the executing mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_cur_lvl <= '0;
            s_cur_lvl <= '0;
            m_code    <= '0;
            s_code    <= '0;
        end else if (take) begin
            if (mode_m) begin
                m_cur_lvl <= pend_lvl;
                m_code    <= pend_code;
            end else begin
                s_cur_lvl <= pend_lvl;
                s_code    <= pend_code;
            end
        end
    end

    AST_ERR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($stable(stat_lo) && $stable(m_cur_lvl) && $stable(s_cur_lvl)
                     && $stable(m_code) && $stable(s_code) && rsp_data == '0)); // R9
    AST_STAT_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((stat_lo & $past(stat_lo)) == $past(stat_lo))); // R8
endmodule

// File: rtl/nxti_csr.sv
// Top of the next-interrupt CSR logic: decodes the access, checks
// legality, and combines the decision, address and state blocks.
// Assumes at most one CSR access per cycle; the evaluation uses the
// executing privilege's fields.
module nxti_csr
    import nxti_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned LVL_W  = 8,
    parameter int unsigned ID_W   = 12,
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_valid,
    input  logic [11:0]       csr_addr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [XLEN-1:0]   wmask,
    input  logic [1:0]        cur_priv,
    input  logic              lvl_mode,
    input  logic [CODE_W-1:0] pend_code,
    input  logic [1:0]        pend_priv,
    input  logic [LVL_W-1:0]  pend_lvl,
    input  logic [ID_W-1:0]   pend_id,
    input  logic              pend_hwvec,
    input  logic [LVL_W-1:0]  m_prev_lvl,
    input  logic [LVL_W-1:0]  s_prev_lvl,
    input  logic [LVL_W-1:0]  m_thresh,
    input  logic [LVL_W-1:0]  s_thresh,
    input  logic [XLEN-1:0]   vec_base,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_data,
    output logic              rsp_err,
    output logic [4:0]        stat_lo,
    output logic [LVL_W-1:0]  m_cur_lvl,
    output logic [LVL_W-1:0]  s_cur_lvl,
    output logic [CODE_W-1:0] m_code,
    output logic [CODE_W-1:0] s_code
);
    logic              hit_m;
    logic              hit_s;
    logic              acc;
    logic              err;
    logic              svc;
    logic              mode_m;
    logic              wr_en;
    logic [STAT_W-1:0] wr_bits;
    logic [XLEN-1:0]   vec_addr;

    // Address decode of the two next-interrupt CSRs.
    always_comb begin
        hit_m = (csr_addr == ADDR_M_NXTI);
        hit_s = (csr_addr == ADDR_S_NXTI);
        acc   = csr_valid && (hit_m || hit_s);
    end

    // Legality: no user or reserved access, machine CSR needs machine mode.
    always_comb begin
        err = (cur_priv == PRV_U) || (cur_priv == PRV_RSV)
           || (hit_m && cur_priv != PRV_M);
        mode_m = (cur_priv == PRV_M);
    end

    // Masked write toward the low status bits.
    always_comb begin
        wr_en   = (wmask != '0);
        wr_bits = wdata[STAT_W-1:0] & wmask[STAT_W-1:0];
    end

    nxti_eval #(.LVL_W(LVL_W), .CODE_W(CODE_W)) u_eval (
        .cur_priv   (cur_priv),
        .lvl_mode   (lvl_mode),
        .pend_code  (pend_code),
        .pend_priv  (pend_priv),
        .pend_lvl   (pend_lvl),
        .pend_hwvec (pend_hwvec),
        .m_prev_lvl (m_prev_lvl),
        .s_prev_lvl (s_prev_lvl),
        .m_thresh   (m_thresh),
        .s_thresh   (s_thresh),
        .svc        (svc)
    );

    nxti_addr #(.XLEN(XLEN), .ID_W(ID_W)) u_addr (
        .vec_base (vec_base),
        .pend_id  (pend_id),
        .vec_addr (vec_addr)
    );

    nxti_state #(.XLEN(XLEN), .LVL_W(LVL_W), .CODE_W(CODE_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .err       (err),
        .svc       (svc),
        .mode_m    (mode_m),
        .wr_en     (wr_en),
        .wr_bits   (wr_bits),
        .vec_addr  (vec_addr),
        .pend_code (pend_code),
        .pend_lvl  (pend_lvl),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_err   (rsp_err),
        .stat_lo   (stat_lo),
        .m_cur_lvl (m_cur_lvl),
        .s_cur_lvl (s_cur_lvl),
        .m_code    (m_code),
        .s_code    (s_code)
    );

    AST_USER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cur_priv == PRV_U) |=> rsp_err); // R9
    AST_M_FROM_S_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && hit_m && cur_priv == PRV_S) |=> rsp_err); // R10
    AST_NO_SVC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !svc) |=> (rsp_data == '0 && $stable(m_cur_lvl) && $stable(s_cur_lvl))); // R7
    AST_M_ABOVE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && cur_priv == PRV_M) |-> (pend_lvl > m_thresh && pend_lvl > m_prev_lvl)); // R2
    AST_PRIV_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        svc |-> (pend_priv == cur_priv && pend_code != '0 && lvl_mode && !pend_hwvec)); // R3
    AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid); // R12
endmodule

// File: tb/tb_nxti_csr.sv
module tb_nxti_csr;
    localparam int XLEN = 32;
    localparam int LVL_W = 8;
    localparam int ID_W = 12;
    localparam int CODE_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csr_valid = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [XLEN-1:0] wdata = '0, wmask = '0;
    logic [1:0] cur_priv = 2'd3;
    logic lvl_mode = 1'b1;
    logic [CODE_W-1:0] pend_code = '0;
    logic [1:0] pend_priv = 2'd3;
    logic [LVL_W-1:0] pend_lvl = '0;
    logic [ID_W-1:0] pend_id = '0;
    logic pend_hwvec = 1'b0;
    logic [LVL_W-1:0] m_prev_lvl = 8'd3, s_prev_lvl = 8'd7, m_thresh = 8'd5, s_thresh = 8'd2;
    logic [XLEN-1:0] vec_base = 32'h8000_0000;
    logic rsp_valid, rsp_err;
    logic [XLEN-1:0] rsp_data;
    logic [4:0] stat_lo;
    logic [LVL_W-1:0] m_cur_lvl, s_cur_lvl;
    logic [CODE_W-1:0] m_code, s_code;

    always #2.5 clk = ~clk;

    nxti_csr dut (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
        .wdata(wdata), .wmask(wmask), .cur_priv(cur_priv), .lvl_mode(lvl_mode),
        .pend_code(pend_code), .pend_priv(pend_priv), .pend_lvl(pend_lvl),
        .pend_id(pend_id), .pend_hwvec(pend_hwvec), .m_prev_lvl(m_prev_lvl),
        .s_prev_lvl(s_prev_lvl), .m_thresh(m_thresh), .s_thresh(s_thresh),
        .vec_base(vec_base), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .stat_lo(stat_lo), .m_cur_lvl(m_cur_lvl),
        .s_cur_lvl(s_cur_lvl), .m_code(m_code), .s_code(s_code)
    );

    typedef struct {
        logic [XLEN-1:0] data;
        logic err;
        logic [4:0] stat;
        logic [LVL_W-1:0] mlvl, slvl;
        logic [CODE_W-1:0] mcode, scode;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    logic [4:0] m_stat = '0;
    logic [LVL_W-1:0] m_ml = '0, m_sl = '0;
    logic [CODE_W-1:0] m_mc = '0, m_sc = '0;

    // Driver: apply one access and push the expected outcome.
    task automatic access(input logic [11:0] a, input logic [1:0] pr,
                          input logic [CODE_W-1:0] code, input logic [1:0] ppr,
                          input logic [LVL_W-1:0] lvl, input logic [ID_W-1:0] id,
                          input logic hv, input logic lm,
                          input logic [XLEN-1:0] wd, input logic [XLEN-1:0] wm,
                          input string tag);
        exp_t e;
        logic hit, bad, ok, take;
        logic [LVL_W-1:0] pv, th, eff;
        @(negedge clk);
        csr_valid = 1'b1; csr_addr = a; cur_priv = pr; pend_code = code;
        pend_priv = ppr; pend_lvl = lvl; pend_id = id; pend_hwvec = hv;
        lvl_mode = lm; wdata = wd; wmask = wm;
        hit = (a == 12'h345) || (a == 12'h145);
        bad = (pr == 2'd0) || (pr == 2'd2) || (a == 12'h345 && pr != 2'd3);
        ok = hit && !bad;
        pv = (pr == 2'd3) ? m_prev_lvl : s_prev_lvl;
        th = (pr == 2'd3) ? m_thresh : s_thresh;
        eff = (pv > th) ? pv : th;
        take = ok && code != 0 && lm && ppr == pr && !hv && lvl > eff;
        if (ok && wm != 0) m_stat = m_stat | (wd[4:0] & wm[4:0]);
        if (take && pr == 2'd3) begin m_ml = lvl; m_mc = code; end
        if (take && pr == 2'd1) begin m_sl = lvl; m_sc = code; end
        e.data = take ? vec_base + {20'd0, id} * 4 : '0;
        e.err = hit && bad;
        e.stat = m_stat; e.mlvl = m_ml; e.slvl = m_sl; e.mcode = m_mc; e.scode = m_sc;
        e.tag = tag;
        if (hit) q.push_back(e);
        @(negedge clk);
        csr_valid = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pop and compare each response as it appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_chk++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL R12: unexpected response data=%h expected none", rsp_data);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rsp_data !== e.data || rsp_err !== e.err || stat_lo !== e.stat ||
                    m_cur_lvl !== e.mlvl || s_cur_lvl !== e.slvl ||
                    m_code !== e.mcode || s_code !== e.scode) begin
                    n_fail++;
                    $display("FAIL %s: got data=%h err=%b stat=%h ml=%0d sl=%0d mc=%h sc=%h exp data=%h err=%b stat=%h ml=%0d sl=%0d mc=%h sc=%h",
                             e.tag, rsp_data, rsp_err, stat_lo, m_cur_lvl, s_cur_lvl, m_code, s_code,
                             e.data, e.err, e.stat, e.mlvl, e.slvl, e.mcode, e.scode);
                end
            end
        end
    end

    initial begin : watchdog
        #(5ns * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 0 || rsp_err !== 0 || rsp_data !== 0 || stat_lo !== 0 ||
            m_cur_lvl !== 0 || s_cur_lvl !== 0 || m_code !== 0 || s_code !== 0) begin
            n_fail++;
            $display("FAIL reset: got valid=%b data=%h stat=%h expected all zero", rsp_valid, rsp_data, stat_lo);
        end
        // M effective level = max(3,5)=5
        access(12'h345, 2'd3, 12'h013, 2'd3, 8'd6, 12'd10, 0, 1, 0, 0, "R1 serviced M");
        access(12'h345, 2'd3, 12'h014, 2'd3, 8'd5, 12'd11, 0, 1, 0, 0, "R2 equal threshold R7");
        m_prev_lvl = 8'd9;
        access(12'h345, 2'd3, 12'h015, 2'd3, 8'd9, 12'd12, 0, 1, 0, 0, "R2 equal prev R7");
        access(12'h345, 2'd3, 12'h016, 2'd3, 8'd10, 12'd13, 0, 1, 0, 0, "R2 one above prev");
        access(12'h345, 2'd3, 12'h017, 2'd1, 8'd50, 12'd14, 0, 1, 0, 0, "R3 priv mismatch");
        access(12'h345, 2'd3, 12'h000, 2'd3, 8'd50, 12'd15, 0, 1, 0, 0, "R4 zero code");
        access(12'h345, 2'd3, 12'h018, 2'd3, 8'd50, 12'd16, 0, 0, 0, 0, "R5 level mode off");
        access(12'h345, 2'd3, 12'h019, 2'd3, 8'd50, 12'd17, 1, 1, 0, 0, "R6 hw vectored R7");
        access(12'h345, 2'd3, 12'h000, 2'd3, 8'd0, 12'd0, 0, 1, 32'hFFFF_FFEA, 32'h0000_0F0F, "R8 masked set");
        access(12'h345, 2'd3, 12'h000, 2'd3, 8'd0, 12'd0, 0, 1, 32'h0000_0005, 32'h0, "R8 zero mask");
        access(12'h345, 2'd3, 12'h000, 2'd3, 8'd0, 12'd0, 0, 1, 32'h0000_0001, 32'h0000_0001, "R8 or bit0");
        access(12'h145, 2'd0, 12'h01A, 2'd0, 8'd200, 12'd5, 0, 1, 32'h10, 32'h10, "R9 user access");
        access(12'h345, 2'd1, 12'h01B, 2'd1, 8'd200, 12'd5, 0, 1, 32'h10, 32'h10, "R10 M csr from S");
        // S effective level = max(7,2)=7
        access(12'h145, 2'd1, 12'h01C, 2'd1, 8'd7, 12'd3, 0, 1, 0, 0, "R11 S equal prev");
        access(12'h145, 2'd1, 12'h01D, 2'd1, 8'd8, 12'd4095, 0, 1, 0, 0, "R11 S serviced max id");
        access(12'h345, 2'd3, 12'h01E, 2'd3, 8'd255, 12'd1, 0, 1, 0, 0, "R1 top level");
        access(12'h344, 2'd3, 12'h01F, 2'd3, 8'd255, 12'd2, 0, 1, 32'h1F, 32'h1F, "R12 other addr");
        repeat (3) @(negedge clk);
        n_chk++;
        if (q.size() != 0 || stat_lo !== m_stat) begin
            n_fail++;
            $display("FAIL R12: pending=%0d stat=%h expected pending=0 stat=%h", q.size(), stat_lo, m_stat);
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule